// File: doc/BRIEF.md
# Three-Channel Shared-Period PWM Generator

This block produces three pulse-width-modulated outputs that share one cycle. A single up-counter runs against a period value. When the counter reaches the period, it returns to zero on the next clock, and every channel is driven to its active level. Each channel has its own duty value. When the counter reaches a channel's duty value, that channel is driven to its opposite level. A per-channel polarity bit chooses which level counts as active, so the same duty value can give either a high-going or a low-going pulse.

A small sequencer controls the counter. Its states are `ST_OFF`, `ST_RUN` and `ST_HOLD`, and its transitions are:

- **start**: `ST_OFF` to `ST_RUN` when `en` is high.
- **pause**: `ST_RUN` to `ST_HOLD` when `en` is low.
- **resume**: `ST_HOLD` to `ST_RUN` when `en` is high.
- **stay**: every other case leaves the state unchanged.

Both start and resume reload the counter to zero and put each output at its polarity-defined starting level. While paused, the counter and the outputs keep their values. One-clock match pulses report the period compare and each duty compare, for use by neighbouring logic.

Top module: `pwm3_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first enabled clock, `pwm_out` is all zero, `match_period` is 0, `match_duty` is all zero and the sequencer is in `ST_OFF`.
- R2: On the first rising edge with `en` high in `ST_OFF` or `ST_HOLD`, the counter loads zero and each `pwm_out[i]` loads `pol[i]`. No match pulse is raised in that loading cycle.
- R3: In `ST_RUN` with `en` high, the counter adds one per clock. On the clock after it equals `period`, it becomes zero. `match_period` therefore repeats every `period`+1 clocks.
- R4: With `pol[i]`=1, `pwm_out[i]` goes to 1 after a period match and to 0 after a match on duty field i.
- R5: With `pol[i]`=0, `pwm_out[i]` goes to 0 after a period match and to 1 after a match on duty field i.
- R6: If duty field i equals `period`, no compare ever changes `pwm_out[i]`.
- R7: A duty field larger than `period` never matches: its `match_duty` bit stays 0 and its output stays at the level set by the period match.
- R8: When `en` is low, the counter and `pwm_out` keep their values and all match pulses are 0.
- R9: Match pulses are combinational on the running cycle. `match_period` is high while running with `en` high and the counter equal to `period`. `match_duty[i]` is high under the same condition with duty field i in place of `period`, which includes the case where the duty field equals `period`.
- R10: Channel i uses bit i of `pol`, `pwm_out` and `match_duty`, and bits [16*i+15:16*i] of `duty_val`. Channels do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low pauses, rising reloads |
| period | input | 16 | Shared period compare value |
| duty_val | input | 48 | Three 16-bit duty compare values, channel 0 in the low bits |
| pol | input | 3 | Per-channel polarity (1: high at period match) |
| pwm_out | output | 3 | PWM output levels |
| match_period | output | 1 | One-clock pulse on period compare |
| match_duty | output | 3 | One-clock pulses on duty compares |

## Verification
The bench sweeps every combination of a small period range (0 to 6), duty values that run past the period, and both polarities. It compares each cycle against an arithmetic model.

- **Period 0 and duty 0.** A design that mishandles these would stall the counter or emit a stray edge.
- **Duty equal to period.** A design that ignores this rule would toggle the output twice or leave it at the wrong level.
- **Duty above period.** A design that gets this wrong would wrap around and fire a late compare.
- **Pause and resume.** A wrong design would keep counting while paused, or resume without reloading the outputs.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    // Sequencer states for the shared counter.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } pwm_state_e;

endpackage

// File: rtl/pwm3_seq.sv
module pwm3_seq
    import pwm3_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_q,
    output pwm_state_e       state_q,
    output logic             load,
    output logic             active,
    output logic             per_hit
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    pwm_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, pause, resume, stay.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (en)  state_d = ST_RUN;   // start
            ST_RUN:  if (!en) state_d = ST_HOLD;  // pause
            ST_HOLD: if (en)  state_d = ST_RUN;   // resume
            default: state_d = ST_OFF;
        endcase
    end

    // Decoded controls for the counter and the channels.
    always_comb begin
        load    = 1'b0;
        active  = 1'b0;
        unique case (state_q)
            ST_OFF, ST_HOLD: load   = en;
            ST_RUN:          active = en;
            default: begin
                load   = 1'b0;
                active = 1'b0;
            end
        endcase
        per_hit = active && (cnt_q == period);
    end

    // Shared up-counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (active) begin
            if (per_hit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/pwm3_chan.sv
module pwm3_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             active,
    input  logic             per_hit,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    input  logic             pol,
    output logic             out_q,
    output logic             duty_hit
);

    logic same_val;
    logic out_d;

    always_comb begin
        same_val = (duty == period);
        duty_hit = active && (cnt == duty);
        out_d    = out_q;
        if (load) begin
            out_d = pol;
        end else if (!same_val) begin
            if (per_hit) begin
                out_d = pol;
            end else if (duty_hit) begin
                out_d = ~pol;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

endmodule

// File: rtl/pwm3_unit.sv
module pwm3_unit
    import pwm3_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [CNT_W-1:0]        period,
    input  logic [NUM_CH*CNT_W-1:0] duty_val,
    input  logic [NUM_CH-1:0]       pol,
    output logic [NUM_CH-1:0]       pwm_out,
    output logic                    match_period,
    output logic [NUM_CH-1:0]       match_duty
);

    logic [CNT_W-1:0] cnt_q;
    pwm_state_e       state_q;
    logic             load;
    logic             active;
    logic             per_hit;

    pwm3_seq #(.CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .period  (period),
        .cnt_q   (cnt_q),
        .state_q (state_q),
        .load    (load),
        .active  (active),
        .per_hit (per_hit)
    );

    assign match_period = per_hit;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        pwm3_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .active   (active),
            .per_hit  (per_hit),
            .cnt      (cnt_q),
            .period   (period),
            .duty     (duty_val[gi*CNT_W +: CNT_W]),
            .pol      (pol[gi]),
            .out_q    (pwm_out[gi]),
            .duty_hit (match_duty[gi])
        );
    end

endmodule

// File: rtl/pwm3_sva.sv
module pwm3_sva #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic [CNT_W-1:0]        period,
    input logic [NUM_CH*CNT_W-1:0] duty_val,
    input logic [NUM_CH-1:0]       pol,
    input logic [NUM_CH-1:0]       pwm_out,
    input logic                    match_period,
    input logic [NUM_CH-1:0]       match_duty,
    input logic [CNT_W-1:0]        cnt_q,
    input logic [1:0]              state_q
);

    localparam logic [1:0] RUN_CODE = 2'd1;

    // R3: a period match restarts the counter at zero.
    a_r3_counter_clears: assert property (@(posedge clk) disable iff (!rst_n)
        match_period |=> (cnt_q == '0));

    // R8: with enable low nothing moves.
    a_r8_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(cnt_q) && $stable(pwm_out)));

    // R9: no pulse without enable.
    a_r9_pulse_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (match_period || (match_duty != '0)) |-> en);

    // R2: the first enabled edge outside ST_RUN loads the counter with zero.
    a_r2_entry_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q != RUN_CODE) |=> (cnt_q == '0 && state_q == RUN_CODE));

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chk
        // R4 and R5: the period match drives the polarity level.
        a_r4_period_level: assert property (@(posedge clk) disable iff (!rst_n)
            (match_period && duty_val[gi*CNT_W +: CNT_W] != period)
            |=> (pwm_out[gi] == $past(pol[gi])));

        // R4 and R5: the duty match drives the opposite level.
        a_r5_duty_level: assert property (@(posedge clk) disable iff (!rst_n)
            (match_duty[gi] && duty_val[gi*CNT_W +: CNT_W] != period)
            |=> (pwm_out[gi] == !$past(pol[gi])));

        // R6: equal duty and period leaves the output untouched.
        a_r6_equal_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == RUN_CODE && duty_val[gi*CNT_W +: CNT_W] == period)
            |=> $stable(pwm_out[gi]));

        // R7: a duty above the period never pulses.
        a_r7_no_match_above: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_val[gi*CNT_W +: CNT_W] > period && cnt_q <= period)
            |-> !match_duty[gi]);
    end

endmodule

bind pwm3_unit pwm3_sva #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .period       (period),
    .duty_val     (duty_val),
    .pol          (pol),
    .pwm_out      (pwm_out),
    .match_period (match_period),
    .match_duty   (match_duty),
    .cnt_q        (cnt_q),
    .state_q      (state_q)
);

// File: tb/tb_pwm3_unit.sv
`timescale 1ns/1ps
module tb_pwm3_unit;

    localparam int W  = 16;
    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [W-1:0]  period = '0;
    logic [NC*W-1:0] duty_val = '0;
    logic [NC-1:0] pol = '0;
    logic [NC-1:0] pwm_out;
    logic          match_period;
    logic [NC-1:0] match_duty;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_pp = -1;
    bit done = 1'b0;

    // Reference model state: 0 off, 1 run, 2 hold.
    int        m_state = 0;
    int        m_cnt = 0;
    logic [NC-1:0] m_out = '0;
    bit        hold_tag = 1'b0;
    bit        entry_tag = 1'b0;

    pwm3_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .period       (period),
        .duty_val     (duty_val),
        .pol          (pol),
        .pwm_out      (pwm_out),
        .match_period (match_period),
        .match_duty   (match_duty)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, got, exp);
        end
    endtask

    function automatic int dfield(input int ch);
        return int'(duty_val[ch*W +: W]);
    endfunction

    function automatic string out_tag(input int ch);
        if (entry_tag) return "R2";
        if (hold_tag) return "R8";
        if (dfield(ch) == int'(period)) return "R6";
        if (dfield(ch) > int'(period)) return "R7";
        if (ch == 1) return "R10";
        return pol[ch] ? "R4" : "R5";
    endfunction

    // One cycle: check outputs against the model, advance the model, move to the next negedge.
    task automatic step();
        bit act;
        bit exp_pp;
        logic [NC-1:0] exp_md;
        #1;
        act = (m_state == 1) && en;
        exp_pp = act && (m_cnt == int'(period));
        for (int ch = 0; ch < NC; ch++) begin
            exp_md[ch] = act && (m_cnt == dfield(ch));
        end
        chk(match_period == exp_pp, en ? "R9" : "R8", int'(match_period), int'(exp_pp));
        for (int ch = 0; ch < NC; ch++) begin
            chk(match_duty[ch] == exp_md[ch], (dfield(ch) > int'(period)) ? "R7" : "R9",
                int'(match_duty[ch]), int'(exp_md[ch]));
            chk(pwm_out[ch] == m_out[ch], out_tag(ch), int'(pwm_out[ch]), int'(m_out[ch]));
        end
        if (exp_pp) begin
            if (last_pp >= 0) begin
                chk((cyc - last_pp) == int'(period) + 1, "R3", cyc - last_pp, int'(period) + 1);
            end
            last_pp = cyc;
        end
        entry_tag = 1'b0;
        if (!en) begin
            if (m_state == 1) m_state = 2;
            hold_tag = 1'b1;
        end else if (m_state != 1) begin
            m_state = 1;
            m_cnt = 0;
            m_out = pol;
            entry_tag = 1'b1;
            hold_tag = 1'b0;
            last_pp = -1;
        end else begin
            hold_tag = 1'b0;
            for (int ch = 0; ch < NC; ch++) begin
                if (dfield(ch) != int'(period)) begin
                    if (m_cnt == int'(period)) m_out[ch] = pol[ch];
                    else if (m_cnt == dfield(ch)) m_out[ch] = ~pol[ch];
                end
            end
            m_cnt = (m_cnt == int'(period)) ? 0 : ((m_cnt + 1) % (1 << W));
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic reset_model();
        m_state = 0;
        m_cnt = 0;
        m_out = '0;
        last_pp = -1;
        entry_tag = 1'b0;
        hold_tag = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset state.
        @(negedge clk);
        #1;
        chk(pwm_out == '0, "R1", int'(pwm_out), 0);
        chk(match_period == 1'b0, "R1", int'(match_period), 0);
        chk(match_duty == '0, "R1", int'(match_duty), 0);
        @(negedge clk);
        rst_n = 1'b1;
        reset_model();
        repeat (2) step();

        // Sweep: period 0..6, duty 0..8, both polarity patterns.
        for (int p = 0; p <= 6; p++) begin
            for (int d = 0; d <= 8; d++) begin
                for (int pl = 0; pl < 2; pl++) begin
                    en = 1'b0;
                    period = W'(p);
                    duty_val[0*W +: W] = W'(d);
                    duty_val[1*W +: W] = W'((d + 3) % 9);
                    duty_val[2*W +: W] = W'(p);
                    pol = pl ? 3'b101 : 3'b010;
                    step();
                    en = 1'b1;
                    for (int k = 0; k < 3 * (p + 1) + 3; k++) step();
                end
            end
        end

        // R8 then R2: pause mid-cycle, hold, resume with reload.
        period = W'(9);
        duty_val = {W'(7), W'(2), W'(5)};
        pol = 3'b011;
        en = 1'b1;
        for (int k = 0; k < 14; k++) step();
        en = 1'b0;
        for (int k = 0; k < 4; k++) step();
        en = 1'b1;
        for (int k = 0; k < 25; k++) step();

        // Polarity flipped while running (R4, R5 follow the live bit).
        pol = 3'b100;
        for (int k = 0; k < 22; k++) step();

        // R1: reset in the middle of a run.
        rst_n = 1'b0;
        #1;
        chk(pwm_out == '0, "R1", int'(pwm_out), 0);
        chk(match_period == 1'b0, "R1", int'(match_period), 0);
        @(negedge clk);
        en = 1'b0;
        rst_n = 1'b1;
        reset_model();
        step();
        en = 1'b1;
        for (int k = 0; k < 25; k++) step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule